// File: doc/BRIEF.md
# Masked Bitwise Ternary Logic Unit

This unit evaluates an arbitrary three-input Boolean function on every bit position of three wide vector operands. The function is not fixed in hardware. It is supplied as an 8-bit truth table with each operation, so a single datapath covers all 256 possible functions of three variables.

The raw result is then filtered per element by a write mask. Elements are either 32 or 64 bits wide. For each masked-off element, the unit either keeps the old destination value (merging) or clears the element (zeroing). Operand A also serves as the old destination value used for merging.

One result is accepted per cycle. The filtered result is registered and appears one cycle after the input, qualified by an output valid.

Top module: `tern_logic_unit`

## Requirements
- R1: While `rst_ni` is low and after its release, `valid_o` is 0 and `res_o` is all zeros until the first accepted input.
- R2: `valid_o` equals `valid_i` from the previous clock cycle.
- R3: An enabled result bit i equals `imm_i[{opa_i[i], opb_i[i], opc_i[i]}]`, with the A bit as index MSB and the C bit as LSB. For example, 0x96 gives A^B^C, 0xE8 gives majority(A,B,C), and 0xF0 gives A.
- R4: Every one of the 256 immediate values produces its truth-table function on random operands.
- R5: With `esz_i` = 0 (32-bit elements, 16 lanes), `mask_i[k]` gates bits [32k+31:32k].
- R6: With `esz_i` = 1 (64-bit elements, 8 lanes), `mask_i[k]` gates bits [64k+63:64k], and `mask_i[15:8]` has no effect.
- R7: With `zero_i` = 0 (merging), each bit of a lane whose mask bit is 0 equals the corresponding bit of `opa_i`.
- R8: With `zero_i` = 1 (zeroing), each bit of a lane whose mask bit is 0 is 0.
- R9: In a cycle with `valid_i` low, `res_o` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Input operands valid |
| opa_i | input | 512 | Operand A. It is also the destination value kept in merging mode |
| opb_i | input | 512 | Operand B |
| opc_i | input | 512 | Operand C |
| imm_i | input | 8 | Truth table, indexed by {A,B,C} |
| esz_i | input | 1 | Element size: 0 selects 32-bit, 1 selects 64-bit |
| mask_i | input | 16 | Per-element write mask |
| zero_i | input | 1 | 1 selects zeroing, 0 selects merging |
| valid_o | output | 1 | Result valid |
| res_o | output | 512 | Masked result |

## Verification
Both the result and its valid are due exactly one clock edge after the inputs are taken. The bench drives an operation on a falling edge and holds `valid_i` through one rising edge. It then reads `res_o` and `valid_o` on the next falling edge, half a period after that rising edge has registered them.

The hold check drives new operands with `valid_i` low for one more full cycle. It then confirms at the following falling edge that `res_o` still holds the earlier value and that `valid_o` has dropped.

// File: rtl/tern_pkg.sv
package tern_pkg;
  localparam int unsigned VEC_W   = 512;
  localparam int unsigned EW_NARR = 32;
  localparam int unsigned EW_WIDE = 64;
  localparam int unsigned MASK_W  = VEC_W / EW_NARR;

  typedef enum logic {
    ESZ_W32 = 1'b0,
    ESZ_W64 = 1'b1
  } esz_e;
endpackage

// File: rtl/tern_bitfunc.sv
module tern_bitfunc #(
  parameter int unsigned DW = 512
) (
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  logic [DW-1:0] c_i,
  input  logic [7:0]    tt_i,
  output logic [DW-1:0] f_o
);
  for (genvar i = 0; i < DW; i++) begin : g_bit
    logic [2:0] idx;
    assign idx    = {a_i[i], b_i[i], c_i[i]};
    assign f_o[i] = tt_i[idx];
  end
endmodule

// File: rtl/tern_lane_en.sv
module tern_lane_en
  import tern_pkg::*;
#(
  parameter int unsigned DW  = 512,
  parameter int unsigned EWN = 32,
  parameter int unsigned EWW = 64
) (
  input  esz_e                  esz_i,
  input  logic [DW/EWN-1:0]     mask_i,
  output logic [DW-1:0]         en_o
);
  localparam int unsigned LN = DW / EWN;
  localparam int unsigned LW = DW / EWW;

  logic [DW-1:0] en_narr, en_wide;

  for (genvar k = 0; k < LN; k++) begin : g_narr
    assign en_narr[k*EWN +: EWN] = {EWN{mask_i[k]}};
  end
  // wide lanes only consume the low LW mask bits
  for (genvar k = 0; k < LW; k++) begin : g_wide
    assign en_wide[k*EWW +: EWW] = {EWW{mask_i[k]}};
  end

  assign en_o = (esz_i == ESZ_W64) ? en_wide : en_narr;
endmodule

// File: rtl/tern_merge.sv
module tern_merge #(
  parameter int unsigned DW = 512
) (
  input  logic [DW-1:0] f_i,
  input  logic [DW-1:0] old_i,
  input  logic [DW-1:0] en_i,
  input  logic          zero_i,
  output logic [DW-1:0] r_o
);
  logic [DW-1:0] fill;
  assign fill = zero_i ? '0 : old_i;
  assign r_o  = (f_i & en_i) | (fill & ~en_i);
endmodule

// File: rtl/tern_logic_unit.sv
module tern_logic_unit
  import tern_pkg::*;
#(
  parameter int unsigned DW  = VEC_W,
  parameter int unsigned EWN = EW_NARR,
  parameter int unsigned EWW = EW_WIDE,
  localparam int unsigned MW = DW / EWN
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  logic [DW-1:0] opa_i,
  input  logic [DW-1:0] opb_i,
  input  logic [DW-1:0] opc_i,
  input  logic [7:0]    imm_i,
  input  logic          esz_i,
  input  logic [MW-1:0] mask_i,
  input  logic          zero_i,
  output logic          valid_o,
  output logic [DW-1:0] res_o
);
  logic [DW-1:0] func, lane_en, masked;
  esz_e          esz;

  assign esz = esz_e'(esz_i);

  tern_bitfunc #(.DW(DW)) u_func (
    .a_i (opa_i),
    .b_i (opb_i),
    .c_i (opc_i),
    .tt_i(imm_i),
    .f_o (func)
  );

  tern_lane_en #(.DW(DW), .EWN(EWN), .EWW(EWW)) u_lane (
    .esz_i (esz),
    .mask_i(mask_i),
    .en_o  (lane_en)
  );

  tern_merge #(.DW(DW)) u_merge (
    .f_i   (func),
    .old_i (opa_i),
    .en_i  (lane_en),
    .zero_i(zero_i),
    .r_o   (masked)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      res_o   <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) res_o <= masked;
    end
  end
endmodule

// File: rtl/tern_logic_unit_chk.sv
module tern_logic_unit_chk #(
  parameter int unsigned DW = 512,
  parameter int unsigned MW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          valid_i,
  input logic [DW-1:0] opa_i,
  input logic [7:0]    imm_i,
  input logic          esz_i,
  input logic [MW-1:0] mask_i,
  input logic          zero_i,
  input logic          valid_o,
  input logic [DW-1:0] res_o
);
  logic full_en, none_narr, none_wide;
  assign full_en   = esz_i ? (&mask_i[MW/2-1:0]) : (&mask_i);
  assign none_narr = (mask_i == '0);
  assign none_wide = (mask_i[MW/2-1:0] == '0);

  // R2
  valid_pipe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o == $past(valid_i));

  // R9
  hold_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(res_o));

  // R3
  pass_a_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && full_en && imm_i == 8'hF0) |=> res_o == $past(opa_i));

  // R3
  const_one_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && full_en && imm_i == 8'hFF) |=> &res_o);

  // R7
  merge_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !zero_i && !esz_i && none_narr) |=> res_o == $past(opa_i));

  // R8
  zero_fill_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && zero_i && !esz_i && none_narr) |=> res_o == '0);

  // R6
  wide_upper_ign_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && zero_i && esz_i && none_wide) |=> res_o == '0);
endmodule

bind tern_logic_unit tern_logic_unit_chk #(.DW(DW), .MW(MW)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .valid_i(valid_i),
  .opa_i  (opa_i),
  .imm_i  (imm_i),
  .esz_i  (esz_i),
  .mask_i (mask_i),
  .zero_i (zero_i),
  .valid_o(valid_o),
  .res_o  (res_o)
);

// File: tb/tern_logic_unit_bench.sv
module tern_logic_unit_bench;
  localparam int DW = 512;
  localparam int MW = 16;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          valid_i = 1'b0;
  logic [DW-1:0] opa_i = '0, opb_i = '0, opc_i = '0;
  logic [7:0]    imm_i = '0;
  logic          esz_i = 1'b0;
  logic [MW-1:0] mask_i = '0;
  logic          zero_i = 1'b0;
  logic          valid_o;
  logic [DW-1:0] res_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk_i = ~clk_i;

  tern_logic_unit u_tern_logic_unit (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i),
    .opa_i(opa_i), .opb_i(opb_i), .opc_i(opc_i), .imm_i(imm_i),
    .esz_i(esz_i), .mask_i(mask_i), .zero_i(zero_i),
    .valid_o(valid_o), .res_o(res_o)
  );

  function automatic logic [DW-1:0] rnd_vec();
    logic [DW-1:0] v;
    for (int i = 0; i < DW/32; i++) v[i*32 +: 32] = $urandom;
    return v;
  endfunction

  function automatic logic [DW-1:0] model(logic [DW-1:0] a, logic [DW-1:0] b,
      logic [DW-1:0] c, logic [7:0] tt, logic sz, logic [MW-1:0] m, logic z);
    logic [DW-1:0] r;
    for (int i = 0; i < DW; i++) begin
      int lane;
      logic f;
      f    = tt[{a[i], b[i], c[i]}];
      lane = sz ? i / 64 : i / 32;
      r[i] = m[lane] ? f : (z ? 1'b0 : a[i]);
    end
    return r;
  endfunction

  task automatic chk_vec(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic chk_bit(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  // drive on falling edge, result sampled one falling edge later
  task automatic run_op(string req, logic [DW-1:0] a, logic [DW-1:0] b,
      logic [DW-1:0] c, logic [7:0] tt, logic sz, logic [MW-1:0] m, logic z);
    @(negedge clk_i);
    opa_i = a; opb_i = b; opc_i = c; imm_i = tt;
    esz_i = sz; mask_i = m; zero_i = z; valid_i = 1'b1;
    @(negedge clk_i);
    valid_i = 1'b0;
    chk_vec(req, res_o, model(a, b, c, tt, sz, m, z));
    chk_bit({req, " valid"}, valid_o, 1'b1);
  endtask

  task automatic t_reset();
    chk_bit("R1 valid", valid_o, 1'b0);
    chk_vec("R1 res", res_o, '0);
  endtask

  task automatic t_named_funcs();
    logic [DW-1:0] a, b, c;
    a = rnd_vec(); b = rnd_vec(); c = rnd_vec();
    run_op("R3 xor3", a, b, c, 8'h96, 1'b0, 16'hFFFF, 1'b0);
    chk_vec("R3 xor3 direct", res_o, a ^ b ^ c);
    run_op("R3 maj", a, b, c, 8'hE8, 1'b0, 16'hFFFF, 1'b0);
    chk_vec("R3 maj direct", res_o, (a & b) | (a & c) | (b & c));
    run_op("R3 passA", a, b, c, 8'hF0, 1'b1, 16'h00FF, 1'b1);
    chk_vec("R3 passA direct", res_o, a);
  endtask

  task automatic t_all_imm();
    for (int t = 0; t < 256; t++)
      run_op("R4 imm sweep", rnd_vec(), rnd_vec(), rnd_vec(), t[7:0], 1'b0, 16'hFFFF, 1'b0);
  endtask

  task automatic t_narrow();
    for (int k = 0; k < 4; k++) begin
      run_op("R5 narrow merge", rnd_vec(), rnd_vec(), rnd_vec(), 8'h96, 1'b0, 16'(1 << (k*5)), 1'b0);
      run_op("R5 narrow zero", rnd_vec(), rnd_vec(), rnd_vec(), 8'h6A, 1'b0, 16'hA5C3, 1'b1);
    end
  endtask

  task automatic t_wide();
    logic [DW-1:0] a, b, c, r0;
    a = rnd_vec(); b = rnd_vec(); c = rnd_vec();
    run_op("R6 wide", a, b, c, 8'hE8, 1'b1, 16'h005A, 1'b1);
    r0 = res_o;
    run_op("R6 wide upper ignored", a, b, c, 8'hE8, 1'b1, 16'hFF5A, 1'b1);
    chk_vec("R6 upper mask no effect", res_o, r0);
    run_op("R6 wide merge", rnd_vec(), rnd_vec(), rnd_vec(), 8'h1E, 1'b1, 16'h0081, 1'b0);
  endtask

  task automatic t_merge_zero();
    logic [DW-1:0] a;
    a = rnd_vec();
    run_op("R7 merge all off", a, rnd_vec(), rnd_vec(), 8'h00, 1'b0, 16'h0000, 1'b0);
    chk_vec("R7 keeps A", res_o, a);
    run_op("R8 zero all off", rnd_vec(), rnd_vec(), rnd_vec(), 8'hFF, 1'b0, 16'h0000, 1'b1);
    chk_vec("R8 all zero", res_o, '0);
  endtask

  task automatic t_hold();
    logic [DW-1:0] r0;
    run_op("R9 setup", rnd_vec(), rnd_vec(), rnd_vec(), 8'h3C, 1'b0, 16'hF0F0, 1'b0);
    r0 = res_o;
    opa_i = rnd_vec(); opb_i = rnd_vec(); imm_i = 8'hFF; mask_i = 16'hFFFF;
    @(negedge clk_i);
    chk_vec("R9 hold", res_o, r0);
    chk_bit("R2 valid low", valid_o, 1'b0);
  endtask

  initial begin
    #(20 * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    if (!done) begin
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_named_funcs();
    t_all_imm();
    t_narrow();
    t_wide();
    t_merge_zero();
    t_hold();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule